// File: doc/BRIEF.md
# Coefficient Staging Buffer with Frame-Aligned Commit

This block sits between a host register port and the parameter RAM of an audio DSP core. It lets a host change up to five coefficient words without the core ever seeing a half-updated set. The host writes coefficient values and their target RAM addresses into staging slots, one byte per bus write. It then sets a commit request bit in the core control register. While that bit is set, the staged set is frozen. On the next audio frame pulse, the block copies the staged words into the RAM in one burst of back-to-back writes, then drops the request bit by itself.

A slot whose target address was not written since the previous commit takes no part in the copy. The host can therefore update any subset of slots. The control register returns its live state on every read. The host polls the request bit, or the busy output, to learn when it may refill the slots.

Top module: `coef_stage_buf`

## Requirements
- R1: After reset, every staging slot reads as zero, no slot is marked valid, the request bit and busy are 0, and pram_we is 0.
- R2: Data slot i is at register DATA_BASE+i (0x0810..0x0814). It takes five bytes: byte index 0 is bits 39:32 and byte index 4 is bits 7:0. It reads back as a 40-bit value.
- R3: Address slot i is at register DATA_BASE+NUM_SLOTS+i (0x0815..0x0819). It takes two bytes: index 0 is bits 15:8 and index 1 is bits 7:0. Writing either byte marks the slot valid.
- R4: The control register is at 0x081C and takes two bytes: index 0 is bits 15:8 and index 1 is bits 7:0. Writing a 1 to bit 5 sets the commit request. All other bits keep the value written. A read returns the live request state in bit 5.
- R5: Writing 0 to bit 5, or any write to the register while a request is pending, leaves the request unchanged. busy equals the pending request.
- R6: A commit begins only on a clock edge where frame_sync is high and the request was already set at an earlier edge. frame_sync with no request, or in the same cycle as the request write, starts nothing.
- R7: The copy visits slots 0 to NUM_SLOTS-1 in order, one per cycle, starting in the cycle after the starting edge. A write drives pram_we with the low PRAM_AW bits of the address slot and the 40-bit data slot.
- R8: A slot that is not valid produces no RAM write in its cycle.
- R9: At the edge that ends the last slot cycle, the request bit, busy and every valid bit clear.
- R10: While a request is pending, writes to data and address slots are ignored. Their contents and valid bits are unchanged.
- R11: Reads of addresses that map to no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Byte write strobe |
| wr_addr | input | 16 | Register address of the write |
| wr_idx | input | 3 | Byte index within the register, 0 = most significant |
| wr_byte | input | 8 | Write data byte |
| rd_addr | input | 16 | Register address for the combinational read |
| rd_data | output | 40 | Read data, zero-extended |
| frame_sync | input | 1 | One-cycle audio frame pulse |
| busy | output | 1 | Commit request pending |
| pram_we | output | 1 | Parameter RAM write enable |
| pram_addr | output | 10 | Parameter RAM word address |
| pram_wdata | output | 40 | Parameter RAM write data |

## Verification
The bench builds the block with its defaults: five slots, 40-bit data, a 10-bit RAM address and the control register at 0x081C. With these values every slot position is reachable, including the last slot, where the request clears. A table walks full, sparse, single-last-slot and empty valid patterns through complete commits, checking each slot cycle. Directed cases place frame pulses before and alongside the request write, attempt refills and request clears while a request is pending, and commit again after a commit to show the valid bits were cleared.

// File: rtl/csb_pkg.sv
package csb_pkg;

  typedef enum logic {ENG_IDLE, ENG_COPY} eng_state_e;

  // Replace one byte of a big-endian register image; index 0 is the top byte.
  // An index at or past the register size leaves the image unchanged.
  function automatic logic [63:0] put_byte(input logic [63:0] cur,
                                           input int unsigned nbytes,
                                           input int unsigned idx,
                                           input logic [7:0] b);
    logic [63:0] r;
    int unsigned sh;
    r = cur;
    if (idx < nbytes) begin
      sh = (nbytes - 1 - idx) * 8;
      r = (cur & ~(64'hFF << sh)) | (64'(b) << sh);
    end
    return r;
  endfunction

endpackage

// File: rtl/csb_slot_bank.sv
module csb_slot_bank #(
  parameter int NUM_SLOTS = 5,
  parameter int DATA_W = 40,
  parameter int SLOT_AW = 16,
  parameter int REG_AW = 16,
  parameter int BIDX_W = 3,
  parameter logic [REG_AW-1:0] DATA_BASE = 16'h0810,
  parameter logic [REG_AW-1:0] ADDR_BASE = 16'h0815
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [7:0] wr_byte,
  input  logic lock,
  input  logic clear_valid,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] data_o,
  output logic [NUM_SLOTS-1:0][SLOT_AW-1:0] addr_o,
  output logic [NUM_SLOTS-1:0] valid_o
);
  import csb_pkg::*;

  localparam int DATA_BYTES = DATA_W / 8;
  localparam int ADDR_BYTES = SLOT_AW / 8;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [REG_AW-1:0] D_REG = REG_AW'(DATA_BASE + s);
    localparam logic [REG_AW-1:0] A_REG = REG_AW'(ADDR_BASE + s);

    logic d_hit, a_hit;
    logic [DATA_W-1:0] data_q;
    logic [SLOT_AW-1:0] addr_q;
    logic valid_q;

    assign d_hit = wr_valid && !lock && (wr_addr == D_REG);
    assign a_hit = wr_valid && !lock && (wr_addr == A_REG);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
      end else if (d_hit) begin
        data_q <= DATA_W'(put_byte(64'(data_q), DATA_BYTES, 32'(wr_idx), wr_byte));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
      end else if (a_hit) begin
        addr_q <= SLOT_AW'(put_byte(64'(addr_q), ADDR_BYTES, 32'(wr_idx), wr_byte));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
      end else if (clear_valid) begin
        valid_q <= 1'b0;
      end else if (a_hit) begin
        valid_q <= 1'b1;
      end
    end

    assign data_o[s]  = data_q;
    assign addr_o[s]  = addr_q;
    assign valid_o[s] = valid_q;
  end

endmodule

// File: rtl/csb_ctrl_reg.sv
module csb_ctrl_reg #(
  parameter int REG_AW = 16,
  parameter int BIDX_W = 3,
  parameter int CTRL_BYTES = 2,
  parameter int TRIG_BIT = 5,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 16'h081C,
  localparam int CW = 8 * CTRL_BYTES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [7:0] wr_byte,
  input  logic clear_trig,
  output logic trig_o,
  output logic [CW-1:0] ctrl_o
);
  import csb_pkg::*;

  logic hit;
  logic [CW-1:0] ctrl_q, ctrl_nxt;
  logic trig_q, trig_req;

  assign hit = wr_valid && (wr_addr == CTRL_ADDR);

  always_comb begin
    ctrl_nxt = CW'(put_byte(64'(ctrl_q), CTRL_BYTES, 32'(wr_idx), wr_byte));
    trig_req = hit && !trig_q && ctrl_nxt[TRIG_BIT];
    ctrl_nxt[TRIG_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hit) begin
      ctrl_q <= ctrl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else if (clear_trig) begin
      trig_q <= 1'b0;
    end else if (trig_req) begin
      trig_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_o = ctrl_q;
    ctrl_o[TRIG_BIT] = trig_q;
  end

  assign trig_o = trig_q;

endmodule

// File: rtl/csb_copy_engine.sv
module csb_copy_engine #(
  parameter int NUM_SLOTS = 5,
  parameter int DATA_W = 40,
  parameter int PRAM_AW = 10,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic frame_sync,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data,
  input  logic [NUM_SLOTS-1:0][PRAM_AW-1:0] slot_addr,
  input  logic [NUM_SLOTS-1:0] slot_valid,
  output logic pram_we,
  output logic [PRAM_AW-1:0] pram_addr,
  output logic [DATA_W-1:0] pram_wdata,
  output logic copy_active,
  output logic commit_start,
  output logic commit_done,
  output logic [IW-1:0] cur_idx
);
  import csb_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(NUM_SLOTS - 1);

  eng_state_e state_q;
  logic [IW-1:0] idx_q;

  assign copy_active  = (state_q == ENG_COPY);
  assign commit_start = (state_q == ENG_IDLE) && trig && frame_sync;
  assign commit_done  = copy_active && (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
    end else if (commit_start) begin
      state_q <= ENG_COPY;
      idx_q   <= '0;
    end else if (commit_done) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
    end else if (copy_active) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign pram_we    = copy_active && slot_valid[idx_q];
  assign pram_addr  = slot_addr[idx_q];
  assign pram_wdata = slot_data[idx_q];
  assign cur_idx    = idx_q;

endmodule

// File: rtl/coef_stage_buf.sv
module coef_stage_buf #(
  parameter int NUM_SLOTS = 5,
  parameter int DATA_W = 40,
  parameter int SLOT_AW = 16,
  parameter int PRAM_AW = 10,
  parameter int REG_AW = 16,
  parameter int CTRL_BYTES = 2,
  parameter int TRIG_BIT = 5,
  parameter logic [REG_AW-1:0] DATA_BASE = 16'h0810,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 16'h081C,
  localparam int BIDX_W = $clog2(DATA_W / 8)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [7:0] wr_byte,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic frame_sync,
  output logic busy,
  output logic pram_we,
  output logic [PRAM_AW-1:0] pram_addr,
  output logic [DATA_W-1:0] pram_wdata
);

  localparam logic [REG_AW-1:0] ADDR_BASE = REG_AW'(DATA_BASE + NUM_SLOTS);
  localparam int CW = 8 * CTRL_BYTES;
  localparam int ENG_IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data;
  logic [NUM_SLOTS-1:0][SLOT_AW-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][PRAM_AW-1:0] slot_paddr;
  logic [NUM_SLOTS-1:0] slot_valid;
  logic trig;
  logic [CW-1:0] ctrl_live;
  logic copy_active, commit_start, commit_done;
  logic [ENG_IW-1:0] cur_idx;

  assign busy = trig;

  csb_slot_bank #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .SLOT_AW(SLOT_AW),
    .REG_AW(REG_AW), .BIDX_W(BIDX_W),
    .DATA_BASE(DATA_BASE), .ADDR_BASE(ADDR_BASE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .lock(trig), .clear_valid(commit_done),
    .data_o(slot_data), .addr_o(slot_addr), .valid_o(slot_valid)
  );

  csb_ctrl_reg #(
    .REG_AW(REG_AW), .BIDX_W(BIDX_W), .CTRL_BYTES(CTRL_BYTES),
    .TRIG_BIT(TRIG_BIT), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .clear_trig(commit_done), .trig_o(trig), .ctrl_o(ctrl_live)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_paddr
    assign slot_paddr[s] = slot_addr[s][PRAM_AW-1:0];
  end

  csb_copy_engine #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .PRAM_AW(PRAM_AW)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .trig(trig), .frame_sync(frame_sync),
    .slot_data(slot_data), .slot_addr(slot_paddr), .slot_valid(slot_valid),
    .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata),
    .copy_active(copy_active), .commit_start(commit_start),
    .commit_done(commit_done), .cur_idx(cur_idx)
  );

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_addr == REG_AW'(DATA_BASE + s)) rd_data = slot_data[s];
      if (rd_addr == REG_AW'(ADDR_BASE + s)) rd_data = DATA_W'(slot_addr[s]);
    end
    if (rd_addr == CTRL_ADDR) rd_data = DATA_W'(ctrl_live);
  end

endmodule

// File: rtl/csb_chk.sv
module csb_chk #(
  parameter int IW = 3,
  parameter int SW = 200
) (
  input logic clk,
  input logic rst_n,
  input logic frame_sync,
  input logic busy,
  input logic copy_active,
  input logic commit_start,
  input logic commit_done,
  input logic pram_we,
  input logic [IW-1:0] cur_idx,
  input logic [SW-1:0] slot_data
);

  // R6
  start_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copy_active) |-> $past(frame_sync) && $past(busy));

  // R6
  start_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |-> busy && !copy_active);

  // R7
  we_in_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pram_we |-> copy_active);

  // R7
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_active && $past(copy_active) |-> cur_idx == IW'($past(cur_idx) + 1'b1));

  // R9
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !busy && !copy_active);

  // R5
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !commit_done |=> busy);

  // R10
  lock_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(slot_data));

endmodule

bind coef_stage_buf csb_chk #(.IW(ENG_IW), .SW(NUM_SLOTS * DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .busy(busy),
  .copy_active(copy_active), .commit_start(commit_start),
  .commit_done(commit_done), .pram_we(pram_we), .cur_idx(cur_idx),
  .slot_data(slot_data)
);

// File: tb/tb_coef_stage_buf.sv
`timescale 1ns/1ps
module tb_coef_stage_buf;

  localparam logic [15:0] DB = 16'h0810;
  localparam logic [15:0] AB = 16'h0815;
  localparam logic [15:0] CA = 16'h081C;

  // {valid mask[52:48], coefficient seed[47:16], address base[15:0]}
  localparam logic [52:0] VEC [4] = '{
    {5'h1F, 32'h11223344, 16'h0100},
    {5'h15, 32'hA5A50F0F, 16'h0200},
    {5'h10, 32'h80000001, 16'h03F0},
    {5'h00, 32'h5555AAAA, 16'h0040}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_byte = '0;
  logic [15:0] rd_addr = '0;
  logic [39:0] rd_data;
  logic frame_sync = 1'b0;
  logic busy, pram_we;
  logic [9:0] pram_addr;
  logic [39:0] pram_wdata;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  coef_stage_buf dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_idx(wr_idx), .wr_byte(wr_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_sync(frame_sync), .busy(busy), .pram_we(pram_we),
    .pram_addr(pram_addr), .pram_wdata(pram_wdata)
  );

  function automatic logic [31:0] coef(input logic [31:0] seed, input int i);
    return seed + 32'(i) * 32'h01010101;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input int b, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_idx = 3'(b); wr_byte = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wr_data(input int s, input logic [31:0] c);
    wr(DB + 16'(s), 0, 8'h00);
    for (int b = 0; b < 4; b++) wr(DB + 16'(s), b + 1, c[(3 - b) * 8 +: 8]);
  endtask

  task automatic wr_addr_slot(input int s, input logic [15:0] a);
    wr(AB + 16'(s), 0, a[15:8]);
    wr(AB + 16'(s), 1, a[7:0]);
  endtask

  task automatic rd(input logic [15:0] a, output logic [39:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic fire_sync;
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  // Expects the copy burst and the release of the request afterwards.
  task automatic expect_copy(input logic [4:0] mask, input logic [31:0] seed,
                             input logic [15:0] base, input string tag);
    logic [39:0] v;
    fire_sync();
    for (int k = 0; k < 5; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      chk({tag, " R7 R8 we"}, 64'(pram_we), 64'(mask[k]));
      if (mask[k]) begin
        chk({tag, " R7 addr"}, 64'(pram_addr), 64'(10'(base + 16'(k))));
        chk({tag, " R7 data"}, 64'(pram_wdata), 64'({8'h00, coef(seed, k)}));
      end
    end
    @(negedge clk);
    #1;
    chk({tag, " R9 busy"}, 64'(busy), 64'd0);
    rd(CA, v);
    chk({tag, " R9 ctrl"}, 64'(v), 64'h0003);
    chk({tag, " R9 we idle"}, 64'(pram_we), 64'd0);
  endtask

  task automatic trigger(input string tag);
    logic [39:0] v;
    wr(CA, 1, 8'h23);
    #1;
    chk({tag, " R5 busy"}, 64'(busy), 64'd1);
    rd(CA, v);
    chk({tag, " R4 ctrl pending"}, 64'(v), 64'h0023);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    logic [39:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;

    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 we", 64'(pram_we), 64'd0);
    rd(CA, v);       chk("R1 ctrl", 64'(v), 64'd0);
    rd(DB + 16'd4, v); chk("R1 data slot", 64'(v), 64'd0);
    rd(AB, v);       chk("R1 addr slot", 64'(v), 64'd0);

    // R4 plain control bits stored, no request
    wr(CA, 1, 8'h03);
    rd(CA, v); chk("R4 ctrl bits", 64'(v), 64'h0003);
    chk("R4 no request", 64'(busy), 64'd0);

    // R2 R3 slot byte order
    wr_data(0, 32'hCAFEF00D);
    wr_addr_slot(0, 16'h0123);
    rd(DB, v); chk("R2 data readback", 64'(v), 64'h00CAFEF00D);
    rd(AB, v); chk("R3 addr readback", 64'(v), 64'h0123);

    // R6 frame pulse with no request does nothing
    fire_sync();
    #1;
    chk("R6 idle sync we", 64'(pram_we), 64'd0);
    @(negedge clk);
    #1;
    chk("R6 idle sync we later", 64'(pram_we), 64'd0);
    chk("R6 idle sync busy", 64'(busy), 64'd0);

    // R6 frame pulse in the same cycle as the request write
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = CA; wr_idx = 3'd1; wr_byte = 8'h23; frame_sync = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; frame_sync = 1'b0;
    #1;
    chk("R6 same cycle no copy", 64'(pram_we), 64'd0);
    chk("R6 same cycle pending", 64'(busy), 64'd1);
    @(negedge clk);
    #1;
    chk("R6 still waiting", 64'(pram_we), 64'd0);

    // R10 refills ignored while pending
    wr_data(0, 32'h12345678);
    wr_addr_slot(1, 16'h0155);
    rd(DB, v); chk("R10 data locked", 64'(v), 64'h00CAFEF00D);
    rd(AB + 16'd1, v); chk("R10 addr locked", 64'(v), 64'd0);

    // R5 writing 0 to the request bit while pending
    wr(CA, 1, 8'h03);
    #1;
    chk("R5 clear ignored", 64'(busy), 64'd1);

    expect_copy(5'h01, 32'hCAFEF00D, 16'h0123, "D1");

    // R8 R9 valid bits cleared by the commit: nothing copies now
    trigger("D2");
    expect_copy(5'h00, 32'h0, 16'h0, "D2 R8");

    // table of patterns
    for (int vi = 0; vi < 4; vi++) begin
      logic [4:0] m;
      logic [31:0] sd;
      logic [15:0] bs;
      m  = VEC[vi][52:48];
      sd = VEC[vi][47:16];
      bs = VEC[vi][15:0];
      for (int s = 0; s < 5; s++) begin
        wr_data(s, coef(sd, s));
        if (m[s]) wr_addr_slot(s, bs + 16'(s));
      end
      rd(DB + 16'd2, v);
      chk("R2 table readback", 64'(v), 64'({8'h00, coef(sd, 2)}));
      trigger("TBL");
      expect_copy(m, sd, bs, "TBL");
    end

    // R11 unmapped read
    rd(16'h0830, v); chk("R11 unmapped", 64'(v), 64'd0);
    rd(16'h081A, v); chk("R11 gap", 64'(v), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule